// File: doc/BRIEF.md
# Exception Entry Controller

This block commits the special-register side effects of entering an exception handler. A general exception request carries a cause code and the faulting program counter, and can also carry a faulting virtual address. A debug request carries a debug cause. The block samples both requests against the current processor status word and decides which one is taken. In a single clock it then writes the saved-PC, cause, address and saved-status registers, produces the next status word with a write strobe, and reports which handler vector the fetch unit should use.

A general exception raised while the exception-mode flag is already set is a nested fault. Its PC goes to a separate double-fault PC register when that register is built in, and the vector becomes the double vector. A debug request is honoured only when the current interrupt level is strictly below the configured debug level. When it is taken, the whole old status word is saved for that level, and the new status word is raised to the debug level.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset every saved register, `psNext`, `psWe` and `takeStrobe` read zero.
- R2: A taken general exception with the exception-mode flag (status bit 4) clear writes the PC to `epc1`. It selects vector 0 (user) when the user-mode flag (status bit 5) is set and vector 1 (kernel) otherwise.
- R3: With the double-fault register built (HAS_DEPC=1), a general exception with bit 4 set writes the PC to `depc`, leaves `epc1` unchanged and selects vector 2 (double).
- R4: With HAS_DEPC=0, a general exception with bit 4 set writes the PC to `epc1`, selects vector 2, and `depc` reads zero.
- R5: A taken general exception writes `excCause` to `causeReg` and presents `psNext` equal to the old status with bit 4 set, together with `psWe`.
- R6: `vaddrReg` takes `excVaddr` on a taken general exception only when `excHasAddr` is high; otherwise it keeps its value.
- R7: A debug request is taken only when the interrupt-level field (status bits 3:0) is strictly below DBG_LEVEL. A blocked debug request alone raises no `takeStrobe` and changes no register.
- R8: A taken debug request writes `dbgCause` to `dbgCauseReg`, the PC to `epcDbg` and the old status word to `epsDbg`. It leaves `epc1`, `depc`, `causeReg` and `vaddrReg` unchanged.
- R9: On a taken debug request `psNext` is the old status with bits 3:0 replaced by DBG_LEVEL and bit 4 set, and the vector is 3 (debug).
- R10: When both requests arrive together, an admissible debug request wins. A blocked debug request lets the general exception through.
- R11: `takeStrobe` and `psWe` pulse for exactly the clock after each cycle with a taken request, and stay low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | General exception request, one cycle |
| excHasAddr | input | 1 | Request carries a faulting virtual address |
| excCause | input | CAUSE_W | General cause code |
| excPc | input | XLEN | Faulting program counter |
| excVaddr | input | XLEN | Faulting virtual address |
| dbgValid | input | 1 | Debug request, one cycle |
| dbgCause | input | DBGC_W | Debug cause code |
| psIn | input | XLEN | Current status word |
| takeStrobe | output | 1 | A request was taken last cycle |
| vecSel | output | 2 | Vector index: 0 user, 1 kernel, 2 double, 3 debug |
| psNext | output | XLEN | New status word |
| psWe | output | 1 | Write strobe for `psNext` |
| epc1 | output | XLEN | Level-1 saved PC |
| depc | output | XLEN | Double-fault saved PC |
| causeReg | output | CAUSE_W | General cause register |
| vaddrReg | output | XLEN | Faulting address register |
| dbgCauseReg | output | DBGC_W | Debug cause register |
| epcDbg | output | XLEN | Saved PC of the debug level |
| epsDbg | output | XLEN | Saved status of the debug level |

## Verification
The hardest case to reach is the collision in which a debug request and a general exception arrive in the same cycle while the interrupt level sits right at the gate. Whether the debug request wins then depends on a one-step difference in a field that random status words seldom land on. The stimulus draws the level from a narrow range around DBG_LEVEL and raises both requests together often. Directed cycles also pin the level at DBG_LEVEL-1 and at DBG_LEVEL with the nested-fault flag set, so that all three register-selection paths are driven from the same collision.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int IL_LSB   = 0;
  localparam int IL_W     = 4;
  localparam int EXCM_BIT = 4;
  localparam int UM_BIT   = 5;

  typedef enum logic [1:0] {
    VEC_USER   = 2'd0,
    VEC_KERNEL = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  typedef struct packed {
    logic genTake;
    logic dbgTake;
    logic toEpc1;
    logic toDepc;
  } ctl_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int DBG_LEVEL = 4,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            excValid,
  input  logic            dbgValid,
  input  logic [IL_W-1:0] levelIn,
  input  logic            excmIn,
  input  logic            umIn,
  output ctl_t            ctl,
  output logic            takeStrobe,
  output vec_e            vecSel
);
  logic levelOk;
  vec_e vecNext;

  always_comb begin
    levelOk     = levelIn < IL_W'(DBG_LEVEL);
    ctl.dbgTake = dbgValid && levelOk;
    ctl.genTake = excValid && !ctl.dbgTake;
    ctl.toDepc  = ctl.genTake && excmIn && HAS_DEPC;
    ctl.toEpc1  = ctl.genTake && !(excmIn && HAS_DEPC);
    if (ctl.dbgTake)  vecNext = VEC_DEBUG;
    else if (excmIn)  vecNext = VEC_DOUBLE;
    else if (umIn)    vecNext = VEC_USER;
    else              vecNext = VEC_KERNEL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeStrobe <= 1'b0;
      vecSel     <= VEC_USER;
    end else begin
      takeStrobe <= ctl.genTake || ctl.dbgTake;
      if (ctl.genTake || ctl.dbgTake) vecSel <= vecNext;
    end
  end

  p_dbg_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dbgValid && !excValid && levelIn >= IL_W'(DBG_LEVEL)) |=> !takeStrobe);

  p_vec_double_r3: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && !dbgValid && excmIn) |=> (takeStrobe && vecSel == VEC_DOUBLE));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && !dbgValid) |=> !takeStrobe);

  p_dbg_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dbgValid && excValid && levelIn < IL_W'(DBG_LEVEL)) |=> vecSel == VEC_DEBUG);
endmodule

// File: rtl/exc_entry_dpath.sv
module exc_entry_dpath
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DBGC_W    = 6,
  parameter int DBG_LEVEL = 4,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_t               ctl,
  input  logic [XLEN-1:0]    excPc,
  input  logic [XLEN-1:0]    excVaddr,
  input  logic               excHasAddr,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [DBGC_W-1:0]  dbgCause,
  input  logic [XLEN-1:0]    psIn,
  output logic [XLEN-1:0]    psNext,
  output logic               psWe,
  output logic [XLEN-1:0]    epc1,
  output logic [XLEN-1:0]    depc,
  output logic [CAUSE_W-1:0] causeReg,
  output logic [XLEN-1:0]    vaddrReg,
  output logic [DBGC_W-1:0]  dbgCauseReg,
  output logic [XLEN-1:0]    epcDbg,
  output logic [XLEN-1:0]    epsDbg
);
  localparam logic [XLEN-1:0] EXCM_MASK = XLEN'(1) << EXCM_BIT;
  localparam logic [XLEN-1:0] IL_MASK   = ((XLEN'(1) << IL_W) - XLEN'(1)) << IL_LSB;
  localparam logic [XLEN-1:0] DBG_FIELD = XLEN'(DBG_LEVEL) << IL_LSB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psNext      <= '0;
      psWe        <= 1'b0;
      epc1        <= '0;
      causeReg    <= '0;
      vaddrReg    <= '0;
      dbgCauseReg <= '0;
      epcDbg      <= '0;
      epsDbg      <= '0;
    end else begin
      psWe <= ctl.genTake || ctl.dbgTake;
      if (ctl.genTake) begin
        causeReg <= excCause;
        psNext   <= psIn | EXCM_MASK;
        if (excHasAddr) vaddrReg <= excVaddr;
        if (ctl.toEpc1) epc1 <= excPc;
      end
      if (ctl.dbgTake) begin
        dbgCauseReg <= dbgCause;
        epcDbg      <= excPc;
        epsDbg      <= psIn;
        psNext      <= (psIn & ~IL_MASK) | DBG_FIELD | EXCM_MASK;
      end
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      always_ff @(posedge clk) begin
        if (!rstN) depc <= '0;
        else if (ctl.toDepc) depc <= excPc;
      end
    end else begin : g_no_depc
      assign depc = '0;
    end
  endgenerate

  p_ps_excm_r5: assert property (@(posedge clk) disable iff (!rstN)
    psWe |-> psNext[EXCM_BIT]);

  p_vaddr_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.genTake && !excHasAddr) |=> $stable(vaddrReg));

  p_eps_copy_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dbgTake |=> epsDbg == $past(psIn));

  p_cause_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dbgTake |=> $stable(causeReg));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DBGC_W    = 6,
  parameter int DBG_LEVEL = 4,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excValid,
  input  logic               excHasAddr,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    excPc,
  input  logic [XLEN-1:0]    excVaddr,
  input  logic               dbgValid,
  input  logic [DBGC_W-1:0]  dbgCause,
  input  logic [XLEN-1:0]    psIn,
  output logic               takeStrobe,
  output logic [1:0]         vecSel,
  output logic [XLEN-1:0]    psNext,
  output logic               psWe,
  output logic [XLEN-1:0]    epc1,
  output logic [XLEN-1:0]    depc,
  output logic [CAUSE_W-1:0] causeReg,
  output logic [XLEN-1:0]    vaddrReg,
  output logic [DBGC_W-1:0]  dbgCauseReg,
  output logic [XLEN-1:0]    epcDbg,
  output logic [XLEN-1:0]    epsDbg
);
  ctl_t ctl;
  vec_e vecQ;

  exc_entry_ctrl #(.DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)) u_ctrl (
    .clk(clk), .rstN(rstN), .excValid(excValid), .dbgValid(dbgValid),
    .levelIn(psIn[IL_LSB +: IL_W]), .excmIn(psIn[EXCM_BIT]), .umIn(psIn[UM_BIT]),
    .ctl(ctl), .takeStrobe(takeStrobe), .vecSel(vecQ)
  );

  assign vecSel = vecQ;

  exc_entry_dpath #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .DBGC_W(DBGC_W),
                    .DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .excPc(excPc), .excVaddr(excVaddr),
    .excHasAddr(excHasAddr), .excCause(excCause), .dbgCause(dbgCause), .psIn(psIn),
    .psNext(psNext), .psWe(psWe), .epc1(epc1), .depc(depc), .causeReg(causeReg),
    .vaddrReg(vaddrReg), .dbgCauseReg(dbgCauseReg), .epcDbg(epcDbg), .epsDbg(epsDbg)
  );
endmodule

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;
  localparam int DL = 4;
  logic clk = 1'b0, rstN = 1'b0;
  logic excValid = 0, excHasAddr = 0, dbgValid = 0;
  logic [5:0]  excCause = 0, dbgCause = 0;
  logic [31:0] excPc = 0, excVaddr = 0, psIn = 0;

  logic        tkA, tkB, weA, weB;
  logic [1:0]  vecA, vecB;
  logic [31:0] psnA, psnB, e1A, e1B, dpA, dpB, vaA, vaB, edA, edB, esA, esB;
  logic [5:0]  caA, caB, dcA, dcB;

  int nTests = 0, nFail = 0;

  always #4 clk = ~clk;

  exc_entry_unit #(.DBG_LEVEL(DL), .HAS_DEPC(1'b1)) dut (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excHasAddr(excHasAddr),
    .excCause(excCause), .excPc(excPc), .excVaddr(excVaddr), .dbgValid(dbgValid),
    .dbgCause(dbgCause), .psIn(psIn), .takeStrobe(tkA), .vecSel(vecA),
    .psNext(psnA), .psWe(weA), .epc1(e1A), .depc(dpA), .causeReg(caA),
    .vaddrReg(vaA), .dbgCauseReg(dcA), .epcDbg(edA), .epsDbg(esA));

  exc_entry_unit #(.DBG_LEVEL(DL), .HAS_DEPC(1'b0)) dutNoDepc (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excHasAddr(excHasAddr),
    .excCause(excCause), .excPc(excPc), .excVaddr(excVaddr), .dbgValid(dbgValid),
    .dbgCause(dbgCause), .psIn(psIn), .takeStrobe(tkB), .vecSel(vecB),
    .psNext(psnB), .psWe(weB), .epc1(e1B), .depc(dpB), .causeReg(caB),
    .vaddrReg(vaB), .dbgCauseReg(dcB), .epcDbg(edB), .epsDbg(esB));

  // expected model state
  logic [31:0] xEpc1A = 0, xEpc1B = 0, xDepc = 0, xVaddr = 0, xEpcDbg = 0, xEps = 0, xPsn = 0;
  logic [5:0]  xCause = 0, xDbgC = 0;
  logic [1:0]  xVecA = 0, xVecB = 0;
  logic        xTake = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] psGen(input logic [31:0] ps);
    return ps | 32'h10;
  endfunction

  function automatic logic [31:0] psDbg(input logic [31:0] ps);
    return (ps & ~32'hF) | 32'(DL) | 32'h10;
  endfunction

  task automatic step(input logic ev, input logic ha, input logic dv, input logic [31:0] ps);
    logic dOk, gTake, excm, um;
    excValid = ev; excHasAddr = ha; dbgValid = dv; psIn = ps;
    excCause = 6'($urandom); dbgCause = 6'($urandom);
    excPc = $urandom; excVaddr = $urandom;
    dOk   = dv && (ps[3:0] < 4'(DL));
    gTake = ev && !dOk;
    excm  = ps[4]; um = ps[5];
    xTake = dOk || gTake;
    if (dOk) begin
      xDbgC = dbgCause; xEpcDbg = excPc; xEps = ps; xPsn = psDbg(ps);
      xVecA = 2'd3; xVecB = 2'd3;
    end else if (gTake) begin
      xCause = excCause; xPsn = psGen(ps);
      if (ha) xVaddr = excVaddr;
      if (excm) begin
        xDepc = excPc; xEpc1B = excPc; xVecA = 2'd2; xVecB = 2'd2;
      end else begin
        xEpc1A = excPc; xEpc1B = excPc;
        xVecA = um ? 2'd0 : 2'd1; xVecB = xVecA;
      end
    end
    @(negedge clk);
    chk("R11", "takeStrobe", 32'(tkA), 32'(xTake));
    chk("R11", "psWe", 32'(weA), 32'(xTake));
    chk("R4", "takeStrobe nodepc", 32'(tkB), 32'(xTake));
    chk("R2/R3 R2", "epc1", e1A, xEpc1A);
    chk("R3", "depc", dpA, xDepc);
    chk("R4", "epc1 nodepc", e1B, xEpc1B);
    chk("R4", "depc nodepc", dpB, 32'h0);
    chk("R5", "causeReg", 32'(caA), 32'(xCause));
    chk("R6", "vaddrReg", vaA, xVaddr);
    chk("R8", "dbgCauseReg", 32'(dcA), 32'(xDbgC));
    chk("R8", "epcDbg", edA, xEpcDbg);
    chk("R8", "epsDbg", esA, xEps);
    if (xTake) begin
      chk(dOk ? "R9" : "R5", "psNext", psnA, xPsn);
      chk(dOk ? "R10" : "R2", "vecSel", 32'(vecA), 32'(xVecA));
      chk("R4", "vecSel nodepc", 32'(vecB), 32'(xVecB));
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "takeStrobe", 32'(tkA), 0);
    chk("R1", "psWe", 32'(weA), 0);
    chk("R1", "psNext", psnA, 0);
    chk("R1", "epc1", e1A, 0);
    chk("R1", "depc", dpA, 0);
    chk("R1", "epsDbg", esA, 0);
    rstN = 1'b1;
    // directed corners
    step(1, 1, 0, 32'h0000_0020);          // R2 user vector
    step(1, 0, 0, 32'h0000_0003);          // R2 kernel, R6 no addr
    step(1, 1, 0, 32'h0000_0010);          // R3/R4 nested fault
    step(0, 0, 1, 32'(DL - 1));            // R7 taken at level DL-1
    step(0, 0, 1, 32'hA5A5_A5A0 | 32'(DL)); // R7 blocked at level DL
    step(1, 1, 1, 32'h0000_0010 | 32'(DL - 1)); // R10 debug wins
    step(1, 1, 1, 32'h0000_0030 | 32'(DL));     // R10 blocked debug, general taken
    step(0, 0, 0, 32'hFFFF_FFFF);          // R11 idle
    step(0, 0, 1, 32'hFFFF_FFE0);          // R9 level 0, upper bits kept
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ps;
      ps = $urandom;
      ps[3:0] = 4'(DL - 2 + int'($urandom % 4));
      step(1'($urandom), 1'($urandom), 1'($urandom), ps);
    end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule